// File: doc/BRIEF.md
# DDR3 Power-Up Command Sequencer

This block brings a DDR3 memory device from power-up to a state ready for normal traffic. A single start pulse makes it request memory power-up and wait, with a bounded timeout, for the power-up-complete status. It then presents a fixed series of memory commands, one at a time, through a command register whose top bit is a start flag. That flag stays set while a command is outstanding and clears by itself once the downstream command issuer accepts the command.

The three mode-register values that depend on timing are computed in hardware from the CAS latency, CAS write latency and write-recovery inputs. These inputs are captured when the start pulse is accepted. Each command is sent to both ranks. A programmable idle interval separates the initial deselect from the precharge-all that follows it. A busy level, a one-cycle completion pulse and a sticky timeout flag report progress to the controlling logic.

Top module: `ddr3_init_seq`

## Requirements
- R1: While reset is asserted, and after it is released, `busy_o`, `done_o`, `err_o`, `pwr_start_o` and all 32 bits of `cmd_word_o` are 0.
- R2: When `start_i` is sampled high in idle, `busy_o` and `pwr_start_o` go high after that same edge. `start_i` is ignored while `busy_o` is high.
- R3: If `pwr_done_i` does not arrive within PWR_TIMEOUT cycles of power-up, `pwr_start_o` is held for exactly PWR_TIMEOUT cycles. `busy_o` then drops, `err_o` rises and stays high until the next accepted start, and no command word is presented.
- R4: After `pwr_done_i`, exactly seven commands are presented in this order: deselect (code 0), precharge-all (code 1), MRS to MR2, MRS to MR3, MRS to MR1, MRS to MR0 (MRS code 3), and ZQ-calibration-long (code 5). The code sits in bits 3:0, and each word sets both rank selects: bit 20 for rank 0 and bit 21 for rank 1.
- R5: Bit 31 of a presented word is the start flag. For MRS, the register number is in bits 18:17 and the register value is in bits 16:4. For every other command, bits 19:4 are zero.
- R6: The start flag and the whole word stay unchanged until `cmd_ack_i` is sampled high. The flag is low after that edge, and the next word appears one cycle later.
- R7: The precharge-all word appears GAP+2 cycles after the edge that accepts the deselect, where GAP is the value of `gap_i` captured at start.
- R8: In MR0, bits 6:4 hold bits 2:0 of (CL-4), and bit 2 holds bit 3 of (CL-4).
- R9: In MR0, bits 11:9 hold tWR-4 when tWR is 8 or less. Otherwise tWR is first rounded up to an even value, and bits 11:9 hold half of that value modulo 8.
- R10: MR0 bit 8 (DLL reset) is 1 and MR0 bits 1:0 (burst length 8) are 0. MR1 is 0x040 (120 ohm termination). MR3 is 0.
- R11: MR2 bits 5:3 hold CWL-5, and all other MR2 bits are 0.
- R12: `busy_o` stays high until the ZQ-calibration-long word is accepted. In the cycle after that edge, `busy_o` is low and `done_o` is high for exactly one cycle.
- R13: `cl_i`, `cwl_i`, `twr_i` and `gap_i` are captured at the accepted start. Changing them during a run does not alter that run's words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for the power-up sequence |
| cl_i | input | 4 | CAS latency in clocks |
| cwl_i | input | 4 | CAS write latency in clocks |
| twr_i | input | 5 | Write recovery in clocks |
| gap_i | input | GAP_W | Idle cycles between deselect and precharge-all |
| pwr_start_o | output | 1 | Power-up request, held while waiting |
| pwr_done_i | input | 1 | Power-up complete status |
| cmd_word_o | output | 32 | Memory command register; bit 31 is the start flag |
| cmd_ack_i | input | 1 | Downstream accepts the pending command |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky power-up timeout flag |

## Verification
The hardest situation to reach from the ports is the interaction between a stalled handshake and the timed gap. The precharge-all spacing must be measured from the exact edge that accepted the deselect, while acknowledgements arrive after varying delays. The bench answers each word after 0 to 2 idle cycles and times every following word against the cycle counter. It does this across several gap values, including zero. Stray start pulses and changed configuration inputs are injected mid-run to show that the captured values govern the run. A run with the power-up response withheld drives the timeout and the sticky error, and a following run clears that error.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

  localparam int WORD_W    = 32;
  localparam int MR_W      = 13;
  localparam int START_BIT = 31;
  localparam int RANK0_BIT = 20;
  localparam int RANK1_BIT = 21;
  localparam int MRNUM_LSB = 17;
  localparam int DATA_LSB  = 4;
  localparam int N_STEPS   = 7;

  localparam logic [3:0] OP_DESEL = 4'd0;
  localparam logic [3:0] OP_PREA  = 4'd1;
  localparam logic [3:0] OP_MRS   = 4'd3;
  localparam logic [3:0] OP_ZQCL  = 4'd5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWR,
    ST_ISSUE,
    ST_HOLD,
    ST_GAP
  } seq_state_e;

  function automatic logic [WORD_W-1:0] mk_cmd(input logic [3:0] op,
                                               input logic [1:0] mrn,
                                               input logic [MR_W-1:0] data);
    logic [WORD_W-1:0] w;
    w = '0;
    w[START_BIT] = 1'b1;
    w[RANK0_BIT] = 1'b1;
    w[RANK1_BIT] = 1'b1;
    w[MRNUM_LSB +: 2] = mrn;
    w[DATA_LSB +: MR_W] = data;
    w[3:0] = op;
    return w;
  endfunction

endpackage

// File: rtl/ddr3_mr_encode.sv
module ddr3_mr_encode
  import ddr3_init_pkg::*;
(
  input  logic [3:0]      cl,
  input  logic [3:0]      cwl,
  input  logic [4:0]      twr,
  output logic [MR_W-1:0] mr0,
  output logic [MR_W-1:0] mr1,
  output logic [MR_W-1:0] mr2,
  output logic [MR_W-1:0] mr3
);

  logic [5:0] twr_even;
  logic [2:0] wr_code;
  logic [3:0] cl_code;
  logic [3:0] cwl_code;

  always_comb begin
    if (twr > 5'd8) twr_even = ({1'b0, twr} + 6'd1) & 6'b111110;
    else            twr_even = {1'b0, twr};
    if (twr_even <= 6'd8) wr_code = 3'(twr_even - 6'd4);
    else                  wr_code = twr_even[3:1];
    cl_code  = cl - 4'd4;
    cwl_code = cwl - 4'd5;

    mr0 = '0;
    mr0[11:9] = wr_code;
    mr0[8]    = 1'b1;
    mr0[6:4]  = cl_code[2:0];
    mr0[2]    = cl_code[3];

    mr1 = '0;
    mr1[6] = 1'b1;

    mr2 = '0;
    mr2[5:3] = cwl_code[2:0];

    mr3 = '0;
  end

  always_comb begin
    a_r10_mr0_fixed_bits: assert (mr0[8] && mr0[1:0] == 2'b00 && mr3 == '0);
  end

endmodule

// File: rtl/ddr3_cmd_reg.sv
module ddr3_cmd_reg
  import ddr3_init_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic              ack,
  output logic [WORD_W-1:0] word_q,
  output logic              pending
);

  logic [WORD_W-1:0] word_d;
  logic              word_en;

  assign pending = word_q[START_BIT];

  always_comb begin
    word_en = 1'b0;
    word_d  = word_q;
    if (load && !pending) begin
      word_en = 1'b1;
      word_d  = word_in;
    end else if (ack && pending) begin
      word_en = 1'b1;
      word_d[START_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  // R6: the flag clears right after acceptance
  a_r6_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pending && ack |=> !pending);
  // R6: an outstanding word does not change
  a_r6_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !ack |=> $stable(word_q));

endmodule

// File: rtl/ddr3_seq_timer.sv
module ddr3_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr || en;
    cnt_d  = clr ? '0 : cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
  import ddr3_init_pkg::*;
#(
  parameter int GAP_W       = 8,
  parameter int PWR_TIMEOUT = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [3:0]        cl_i,
  input  logic [3:0]        cwl_i,
  input  logic [4:0]        twr_i,
  input  logic [GAP_W-1:0]  gap_i,
  output logic              pwr_start_o,
  input  logic              pwr_done_i,
  output logic [WORD_W-1:0] cmd_word_o,
  input  logic              cmd_ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);

  localparam int TMR_MAX  = (PWR_TIMEOUT > (1 << GAP_W)) ? PWR_TIMEOUT : (1 << GAP_W);
  localparam int TMR_W    = $clog2(TMR_MAX + 1);
  localparam int STEP_W   = $clog2(N_STEPS);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS - 1);

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s_n  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s_n  <= rst_meta;
    end
  end

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              cfg_en;
  logic [3:0]        cl_q, cwl_q;
  logic [4:0]        twr_q;
  logic [GAP_W-1:0]  gap_q;
  logic              tmr_clr, tmr_en;
  logic [TMR_W-1:0]  tmr_cnt;
  logic              ld, pending;
  logic [WORD_W-1:0] word_next;
  logic [MR_W-1:0]   mr0, mr1, mr2, mr3;

  ddr3_mr_encode u_enc (
    .cl(cl_q), .cwl(cwl_q), .twr(twr_q),
    .mr0(mr0), .mr1(mr1), .mr2(mr2), .mr3(mr3)
  );

  ddr3_seq_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_s_n), .clr(tmr_clr), .en(tmr_en), .cnt(tmr_cnt)
  );

  ddr3_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_s_n), .load(ld), .word_in(word_next),
    .ack(cmd_ack_i), .word_q(cmd_word_o), .pending(pending)
  );

  always_comb begin
    case (step_q)
      3'd0:    word_next = mk_cmd(OP_DESEL, 2'd0, '0);
      3'd1:    word_next = mk_cmd(OP_PREA,  2'd0, '0);
      3'd2:    word_next = mk_cmd(OP_MRS,   2'd2, mr2);
      3'd3:    word_next = mk_cmd(OP_MRS,   2'd3, mr3);
      3'd4:    word_next = mk_cmd(OP_MRS,   2'd1, mr1);
      3'd5:    word_next = mk_cmd(OP_MRS,   2'd0, mr0);
      default: word_next = mk_cmd(OP_ZQCL,  2'd0, '0);
    endcase
  end

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    done_d  = 1'b0;
    err_d   = err_q;
    cfg_en  = 1'b0;
    tmr_clr = 1'b0;
    tmr_en  = 1'b0;
    ld      = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_PWR;
        step_d  = '0;
        err_d   = 1'b0;
        cfg_en  = 1'b1;
        tmr_clr = 1'b1;
      end
      ST_PWR: begin
        if (pwr_done_i) state_d = ST_ISSUE;
        else if (tmr_cnt == TMR_W'(PWR_TIMEOUT - 1)) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end else tmr_en = 1'b1;
      end
      ST_ISSUE: begin
        ld      = 1'b1;
        state_d = ST_HOLD;
      end
      ST_HOLD: if (cmd_ack_i && pending) begin
        if (step_q == LAST_STEP) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else if (step_q == '0) begin
          state_d = ST_GAP;
          step_d  = step_q + STEP_W'(1);
          tmr_clr = 1'b1;
        end else begin
          state_d = ST_ISSUE;
          step_d  = step_q + STEP_W'(1);
        end
      end
      ST_GAP: begin
        if (tmr_cnt >= TMR_W'(gap_q)) state_d = ST_ISSUE;
        else tmr_en = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cl_q  <= '0;
      cwl_q <= '0;
      twr_q <= '0;
      gap_q <= '0;
    end else if (cfg_en) begin
      cl_q  <= cl_i;
      cwl_q <= cwl_i;
      twr_q <= twr_i;
      gap_q <= gap_i;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign pwr_start_o = (state_q == ST_PWR);
  assign done_o      = done_q;
  assign err_o       = err_q;

  // R12: leaving busy always reports completion or timeout
  a_r12_end_reported: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(busy_o) |-> (done_o || err_o));
  // R12: completion is a single-cycle pulse
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_s_n)
    done_o |=> !done_o);
  // R3: no command is outstanding while power-up is pending
  a_r3_no_cmd_in_pwr: assert property (@(posedge clk) disable iff (!rst_s_n)
    pwr_start_o |-> !cmd_word_o[START_BIT]);
  // R3: a timeout never coincides with completion
  a_r3_err_excl_done: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(done_o && err_o));
  // R2: a start accepted in idle enters power-up
  a_r2_start_enters_pwr: assert property (@(posedge clk) disable iff (!rst_s_n)
    start_i && !busy_o |=> pwr_start_o);

endmodule

// File: tb/ddr3_init_seq_bench.sv
module ddr3_init_seq_bench;

  localparam int T_OUT = 40;
  localparam int GW    = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  cl_i = 4'd6;
  logic [3:0]  cwl_i = 4'd5;
  logic [4:0]  twr_i = 5'd6;
  logic [GW-1:0] gap_i = '0;
  logic        pwr_done_i = 1'b0;
  logic        cmd_ack_i = 1'b0;
  logic        pwr_start_o, busy_o, done_o, err_o;
  logic [31:0] cmd_word_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pwr_delay = 3;
  bit pwr_en = 1'b1;
  int n_seen = 0;

  logic [31:0] exp_q[$];
  int          dist_q[$];

  ddr3_init_seq #(.GAP_W(GW), .PWR_TIMEOUT(T_OUT)) u_ddr3_init_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cl_i(cl_i), .cwl_i(cwl_i),
    .twr_i(twr_i), .gap_i(gap_i), .pwr_start_o(pwr_start_o),
    .pwr_done_i(pwr_done_i), .cmd_word_o(cmd_word_o), .cmd_ack_i(cmd_ack_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] cmdw(input int op, input int mrn, input int data);
    return 32'h8000_0000 | 32'h0030_0000 | (32'(mrn) << 17) | (32'(data) << 4) | 32'(op);
  endfunction

  function automatic int mr0_of(input int cl, input int twr);
    int wr, te, c;
    if (twr <= 8) wr = twr - 4;
    else begin
      te = (twr % 2 == 1) ? twr + 1 : twr;
      wr = (te / 2) % 8;
    end
    c = cl - 4;
    return (wr << 9) | 256 | ((c % 8) << 4) | ((c / 8) << 2);
  endfunction

  // power-up responder
  initial begin
    int n;
    n = 0;
    forever begin
      @(negedge clk);
      if (pwr_start_o && pwr_en) begin
        n++;
        if (n >= pwr_delay) pwr_done_i = 1'b1;
      end else begin
        n = 0;
        pwr_done_i = 1'b0;
      end
    end
  end

  // monitor and acknowledger: scoreboard consumer
  initial begin
    logic [31:0] w, e;
    int ack_cyc, word_cyc, d;
    ack_cyc = 0;
    forever begin
      @(negedge clk);
      if (cmd_word_o[31]) begin
        word_cyc = cyc;
        w = cmd_word_o;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4", "unexpected command word", w, 32'h0);
        end else begin
          e = exp_q.pop_front();
          d = dist_q.pop_front();
          chk(w == e, "R4/R5", "command word", w, e);
          if (d > 0) chk(word_cyc - ack_cyc == d,
                         (d == 1) ? "R6" : "R7", "cycles since accept",
                         32'(word_cyc - ack_cyc), 32'(d));
        end
        for (int k = 0; k < n_seen % 3; k++) begin
          @(negedge clk);
          chk(cmd_word_o == w, "R6", "word held until accepted", cmd_word_o, w);
        end
        n_seen++;
        cmd_ack_i = 1'b1;
        @(negedge clk);
        cmd_ack_i = 1'b0;
        ack_cyc = cyc;
        chk(cmd_word_o[31] == 1'b0, "R6", "start flag after accept",
            32'(cmd_word_o[31]), 32'h0);
      end
    end
  end

  task automatic run_seq(input int cl, input int cwl, input int twr, input int gap,
                         input bit poke);
    int n;
    cl_i = 4'(cl); cwl_i = 4'(cwl); twr_i = 5'(twr); gap_i = GW'(gap);
    exp_q.push_back(cmdw(0, 0, 0));                       dist_q.push_back(0);
    exp_q.push_back(cmdw(1, 0, 0));                       dist_q.push_back(gap + 2);
    exp_q.push_back(cmdw(3, 2, ((cwl - 5) % 8) << 3));    dist_q.push_back(1);
    exp_q.push_back(cmdw(3, 3, 0));                       dist_q.push_back(1);
    exp_q.push_back(cmdw(3, 1, 64));                      dist_q.push_back(1);
    exp_q.push_back(cmdw(3, 0, mr0_of(cl, twr)));         dist_q.push_back(1);
    exp_q.push_back(cmdw(5, 0, 0));                       dist_q.push_back(1);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && pwr_start_o, "R2", "busy and power-up after start",
        {30'd0, busy_o, pwr_start_o}, 32'h3);
    // R13: change configuration mid-run
    cl_i = 4'd14; cwl_i = 4'd12; twr_i = 5'd15; gap_i = GW'(9);
    n = 0;
    while (!done_o && n < 3000) begin
      @(negedge clk);
      n++;
      if (poke && n == 12) start_i = 1'b1;
      if (poke && n == 13) start_i = 1'b0;
    end
    chk(done_o == 1'b1, "R12", "done pulse seen", 32'(done_o), 32'h1);
    chk(busy_o == 1'b0, "R12", "busy low with done", 32'(busy_o), 32'h0);
    chk(exp_q.size() == 0, "R4", "all seven commands issued", 32'(exp_q.size()), 32'h0);
    @(negedge clk);
    chk(done_o == 1'b0, "R12", "done lasts one cycle", 32'(done_o), 32'h0);
    repeat (4) @(negedge clk);
    chk(!busy_o && !pwr_start_o, "R2", "no restart from ignored start",
        {30'd0, busy_o, pwr_start_o}, 32'h0);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (2) @(negedge clk);
    chk({busy_o, done_o, err_o, pwr_start_o} == 4'b0, "R1", "flags in reset",
        {28'd0, busy_o, done_o, err_o, pwr_start_o}, 32'h0);
    chk(cmd_word_o == 32'h0, "R1", "command word in reset", cmd_word_o, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy_o, done_o, err_o, pwr_start_o} == 4'b0, "R1", "flags after reset",
        {28'd0, busy_o, done_o, err_o, pwr_start_o}, 32'h0);

    run_seq(6, 5, 6, 3, 1'b1);    // R8 R9 R10 R11 base case, stray start
    pwr_delay = 1;
    run_seq(11, 8, 11, 0, 1'b0);  // R9 odd tWR rounded to 12, zero gap R7
    pwr_delay = 7;
    run_seq(13, 10, 16, 7, 1'b0); // R8 split CL bit, R9 tWR 16 wraps to 0
    run_seq(7, 6, 8, 1, 1'b1);    // R9 tWR at 8 boundary
    run_seq(9, 7, 9, 2, 1'b0);    // R13 config captured, tWR 9 rounds to 10

    // R3: power-up timeout
    pwr_en = 1'b0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (pwr_start_o && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(n == T_OUT, "R3", "power-up wait length", 32'(n), 32'(T_OUT));
    chk(err_o && !busy_o, "R3", "error raised and idle",
        {30'd0, err_o, busy_o}, 32'h2);
    repeat (5) @(negedge clk);
    chk(err_o == 1'b1, "R3", "error sticky", 32'(err_o), 32'h1);
    chk(cmd_word_o[31] == 1'b0, "R3", "no command after timeout",
        32'(cmd_word_o[31]), 32'h0);
    pwr_en = 1'b1;
    pwr_delay = 2;
    fork
      run_seq(10, 7, 12, 4, 1'b0);
      begin
        @(negedge clk);
        chk(err_o == 1'b0, "R3", "error cleared by new start", 32'(err_o), 32'h0);
      end
    join

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule